// File: doc/BRIEF.md
# Wiper Position Register with Non-Volatile Initial Value

This controller sits behind a serial-bus front end in a digitally controlled resistor. It keeps three pieces of state: the volatile wiper code that drives the resistor switch array, a non-volatile initial value that survives a soft reset, and a one-bit access mode. The front end hands it decoded byte writes, byte reads and the end-of-transfer (STOP) event. The controller decides which registers each access touches.

With the access mode clear, address 0 is a mirrored location. A write loads the wiper at once and stages the byte for the non-volatile store. A read returns the stored initial value. The STOP that ends the transfer starts a self-timed store cycle, and `busy` stays high for the whole cycle. With the access mode set, address 0 is the wiper alone and nothing is stored. The non-volatile value can therefore never change without the wiper taking the same value.

After any reset the wiper starts at midscale. Once the supply is reported good and a recall delay has elapsed, the stored initial value is copied into the wiper. The recall delay and the store cycle length are parameters in microseconds, and they are converted to clock cycles from the clock-frequency parameter.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: During and right after any reset, `wiper` is 80h, `busy` is 1, `rd_data` is 00h and the access mode is cleared.
- R2: After reset, once `supply_ok` is sampled high, `busy` stays high for exactly RECALL_CYC further cycles. When it falls, `wiper` equals the stored initial value.
- R3: With the access mode clear, an accepted write to address 0 sets `wiper` to the data on the clock edge that samples the request. A read of address 0 returns the stored initial value, which is the last committed value and not one still pending.
- R4: With the access mode set, an accepted write to address 0 updates `wiper` only, a read of address 0 returns `wiper`, and a later STOP starts no store cycle.
- R5: A STOP that follows an address-0 write made with the access mode clear raises `busy` for exactly NV_CYC cycles. The staged byte then becomes the stored initial value.
- R6: A write to address 2 keeps only data bit 7 as the access mode. A read of address 2 returns 80h when the mode is set and 00h when it is clear.
- R7: Any address other than 0 and 2 reads as 00h. Writes to it change neither `wiper`, the stored value nor the mode, and they start no store cycle.
- R8: While `busy` is high, read and write requests are ignored: `wiper`, the mode and `rd_data` keep their values.
- R9: A soft reset (`rst_n`) leaves the stored initial value intact, so the recall brings it back. A cold reset (`cold_rst_n`) returns it to 80h.
- R10: A STOP with no pending store leaves `busy` low.
- R11: `rd_data` is registered. It takes the read result on the edge that samples an accepted `req_rd` and holds it until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| cold_rst_n | input | 1 | Synchronous active-low cold reset; also clears the stored initial value to 80h |
| rst_n | input | 1 | Synchronous active-low soft reset; the stored initial value is kept |
| supply_ok | input | 1 | Supply reported valid; enables the power-up recall |
| req_wr | input | 1 | One-cycle pulse: the last data bit of a write byte has been received |
| req_rd | input | 1 | One-cycle pulse: the front end needs a read byte |
| req_addr | input | ADDR_W | Register address of the request |
| req_wdata | input | DATA_W | Write data byte |
| bus_stop | input | 1 | One-cycle pulse on a bus STOP condition |
| rd_data | output | DATA_W | Registered read result |
| wiper | output | DATA_W | Wiper code to the resistor array |
| busy | output | 1 | High during reset, recall and the store cycle |

## Verification
The assertions assume that the front end pulses `req_wr`, `req_rd` and `bus_stop` for one cycle each and never in the same cycle. They also assume that a STOP comes at least one cycle after the write it closes, so the pending flag is already visible when the STOP arrives. The stimulus drives every request from a task that raises one request for one cycle and drops it before the next. STOPs are issued only as separate operations. Random operations mix writes, reads, reserved addresses and STOPs, and the directed cases place requests inside the store cycle and reset in both forms.

// File: rtl/wnv_pkg.sv
// Shared types for the wiper / non-volatile controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package wnv_pkg;

    // Sequencer phases: wait for supply, recall delay, idle, store cycle.
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_RECALL = 2'd1,
        ST_IDLE   = 2'd2,
        ST_NVWR   = 2'd3
    } wnv_state_t;

endpackage

// File: rtl/wnv_seq.sv
// Phase sequencer: power-up wait, recall delay, idle, self-timed store.
// Emits one-cycle recall and commit strobes on the last cycle of each timed
// phase. Assumes bus_stop and nv_pend come from separate cycles of the bus.
module wnv_seq
    import wnv_pkg::*;
#(
    parameter int RECALL_CYC = 50,
    parameter int NV_CYC     = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic bus_stop,
    input  logic nv_pend,
    output logic idle,
    output logic busy,
    output logic recall,
    output logic commit
);
    localparam int MAX_CYC = (NV_CYC > RECALL_CYC) ? NV_CYC : RECALL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    wnv_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Phase register and shared down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            cnt   <= '0;
        end else begin
            case (state)
                ST_WAIT: if (supply_ok) begin
                    state <= ST_RECALL;
                    cnt   <= CNT_W'(RECALL_CYC - 1);
                end
                ST_RECALL: if (cnt == '0) state <= ST_IDLE;
                           else           cnt   <= cnt - 1'b1;
                ST_IDLE: if (bus_stop && nv_pend) begin
                    state <= ST_NVWR;
                    cnt   <= CNT_W'(NV_CYC - 1);
                end
                ST_NVWR: if (cnt == '0) state <= ST_IDLE;
                         else           cnt   <= cnt - 1'b1;
                default: state <= ST_WAIT;
            endcase
        end
    end

    // Strobes and status derived from the phase.
    always_comb begin
        idle   = (state == ST_IDLE);
        busy   = !idle;
        recall = (state == ST_RECALL) && (cnt == '0);
        commit = (state == ST_NVWR) && (cnt == '0);
    end

    // R10
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !(bus_stop && nv_pend)) |=> idle);

    // R5
    store_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NVWR) |-> (int'(cnt) < NV_CYC));

    // R5
    store_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && bus_stop && nv_pend) |=> (state == ST_NVWR));
endmodule

// File: rtl/wnv_nvcell.sv
// Non-volatile initial-value cell. Survives the soft reset; only the cold
// reset returns it to the shipping value. Loaded solely by the commit strobe.
module wnv_nvcell #(
    parameter int               DATA_W = 8,
    parameter logic [DATA_W-1:0] SHIP  = 8'h80
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Storage element with cold-only reset.
    always_ff @(posedge clk) begin
        if (!cold_rst_n)  q <= SHIP;
        else if (commit)  q <= wdata;
    end

    // R9
    nv_stable_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !commit |=> $stable(q));
endmodule

// File: rtl/wnv_regs.sv
// Volatile registers: wiper, access mode bit, staged store byte, read mux.
// Decodes requests only while the sequencer is idle. Assumes single-cycle
// request pulses from the bus front end.
module wnv_regs #(
    parameter int                DATA_W = 8,
    parameter int                ADDR_W = 8,
    parameter logic [DATA_W-1:0] MID    = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              recall,
    input  logic              commit,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ivr_q,
    output logic [DATA_W-1:0] wiper,
    output logic [DATA_W-1:0] stage,
    output logic              nv_pend,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] A_WIPER = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(2);

    logic mode_vol;
    logic wr_acc, rd_acc, hit_wiper, hit_mode;

    // Request qualification and address decode.
    always_comb begin
        wr_acc    = req_wr && idle;
        rd_acc    = req_rd && idle;
        hit_wiper = (req_addr == A_WIPER);
        hit_mode  = (req_addr == A_MODE);
    end

    // Wiper code: midscale on reset, recall, or direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     wiper <= MID;
        else if (recall)                wiper <= ivr_q;
        else if (wr_acc && hit_wiper)   wiper <= req_wdata;
    end

    // Access mode: only the top data bit is kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mode_vol <= 1'b0;
        else if (wr_acc && hit_mode)  mode_vol <= req_wdata[DATA_W-1];
    end

    // Staged byte and pending flag for the next store cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_pend <= 1'b0;
            stage   <= MID;
        end else if (commit) begin
            nv_pend <= 1'b0;
        end else if (wr_acc && hit_wiper && !mode_vol) begin
            nv_pend <= 1'b1;
            stage   <= req_wdata;
        end
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_acc) begin
            if (hit_wiper)     rd_data <= mode_vol ? wiper : ivr_q;
            else if (hit_mode) rd_data <= {mode_vol, {(DATA_W-1){1'b0}}};
            else               rd_data <= '0;
        end
    end

    // R3
    wiper_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hit_wiper) |=> (wiper == $past(req_wdata)));

    // R4
    vol_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && hit_wiper && mode_vol) |=> ($stable(nv_pend) && $stable(stage)));

    // R7
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !hit_wiper && !hit_mode) |=> ($stable(wiper) && $stable(mode_vol) && $stable(nv_pend)));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !recall) |=> ($stable(wiper) && $stable(mode_vol) && $stable(rd_data)));

    // R6
    mode_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && hit_mode) |=> (rd_data[DATA_W-2:0] == '0));
endmodule

// File: rtl/wiper_nv_ctrl.sv
// Top level: wiper register with non-volatile initial value.
// Converts the microsecond timing parameters to clock cycles, combines the
// two resets for the volatile side and wires sequencer, registers and cell.
// Assumes CLK_HZ is a whole number of MHz.
module wiper_nv_ctrl #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int CLK_HZ      = 50_000_000,
    parameter int NV_WRITE_US = 20_000,
    parameter int RECALL_US   = 3_000
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_stop,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wiper,
    output logic              busy
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int NV_CYC     = (CYC_PER_US * NV_WRITE_US < 1) ? 1 : CYC_PER_US * NV_WRITE_US;
    localparam int RECALL_CYC = (CYC_PER_US * RECALL_US < 1) ? 1 : CYC_PER_US * RECALL_US;
    localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};

    logic              sys_rst_n;
    logic              idle, recall, commit, nv_pend;
    logic [DATA_W-1:0] stage, ivr_q;

    // Either reset clears the volatile side.
    always_comb sys_rst_n = rst_n && cold_rst_n;

    wnv_seq #(
        .RECALL_CYC (RECALL_CYC),
        .NV_CYC     (NV_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .supply_ok (supply_ok),
        .bus_stop  (bus_stop),
        .nv_pend   (nv_pend),
        .idle      (idle),
        .busy      (busy),
        .recall    (recall),
        .commit    (commit)
    );

    wnv_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .MID    (MIDSCALE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .idle      (idle),
        .recall    (recall),
        .commit    (commit),
        .req_wr    (req_wr),
        .req_rd    (req_rd),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ivr_q     (ivr_q),
        .wiper     (wiper),
        .stage     (stage),
        .nv_pend   (nv_pend),
        .rd_data   (rd_data)
    );

    wnv_nvcell #(
        .DATA_W (DATA_W),
        .SHIP   (MIDSCALE)
    ) u_nv (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .commit     (commit),
        .wdata      (stage),
        .q          (ivr_q)
    );

    // R1
    reset_mid_chk: assert property (@(posedge clk)
        !sys_rst_n |=> (wiper == MIDSCALE && busy));

    // R2
    recall_load_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        recall |=> (wiper == $past(ivr_q) && !busy));
endmodule

// File: tb/wiper_nv_ctrl_test.sv
// Self-checking bench for wiper_nv_ctrl: directed corners plus seeded
// random operations against a bench-side register model.
module wiper_nv_ctrl_test;
    timeunit 1ns;
    timeprecision 1ns;

    localparam int CLK_HZ  = 50_000_000;
    localparam int NV_CYC  = 50;   // 1 us at 50 MHz
    localparam int REC_CYC = 50;

    logic       clk = 1'b0;
    logic       cold_rst_n, rst_n, supply_ok;
    logic       req_wr, req_rd, bus_stop;
    logic [7:0] req_addr, req_wdata;
    logic [7:0] rd_data, wiper;
    logic       busy;

    int vectors = 0;
    int fails   = 0;

    // Bench model of the block state.
    logic [7:0] m_wiper, m_ivr, m_stage, m_rd;
    logic       m_mode, m_pend;

    always #10 clk = ~clk;

    wiper_nv_ctrl #(
        .CLK_HZ      (CLK_HZ),
        .NV_WRITE_US (1),
        .RECALL_US   (1)
    ) uut (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .req_wr     (req_wr),
        .req_rd     (req_rd),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bus_stop   (bus_stop),
        .rd_data    (rd_data),
        .wiper      (wiper),
        .busy       (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'd0)      return m_mode ? m_wiper : m_ivr;
        else if (a == 8'd2) return {m_mode, 7'd0};
        else                return 8'h00;
    endfunction

    // Write request, one cycle; model updated only when idle.
    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit idle_now);
        @(negedge clk);
        req_wr = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_wr = 1'b0;
        if (idle_now) begin
            if (a == 8'd0) begin
                m_wiper = d;
                if (!m_mode) begin m_pend = 1'b1; m_stage = d; end
            end else if (a == 8'd2) m_mode = d[7];
        end
    endtask

    task automatic do_read(input logic [7:0] a, input bit idle_now, input string req);
        @(negedge clk);
        req_rd = 1'b1; req_addr = a;
        @(negedge clk);
        req_rd = 1'b0;
        if (idle_now) m_rd = exp_read(a);
        chk(req, rd_data, m_rd);
    endtask

    // STOP pulse, then count the busy cycles.
    task automatic do_stop(input string req);
        int n = 0;
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        if (m_pend) begin
            chk(req, n, NV_CYC);
            m_ivr  = m_stage;
            m_pend = 1'b0;
        end else chk(req, n, 0);
    endtask

    // Reset then supply-good recall, checking R1 and R2.
    task automatic do_reset(input bit cold);
        int n = 0;
        @(negedge clk);
        supply_ok = 1'b0; rst_n = 1'b0;
        if (cold) cold_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; cold_rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 wiper", wiper, 8'h80);
        chk("R1 busy", busy, 1);
        chk("R1 rd_data", rd_data, 8'h00);
        if (cold) m_ivr = 8'h80;
        m_mode = 1'b0; m_pend = 1'b0; m_rd = 8'h00;
        supply_ok = 1'b1;
        @(negedge clk);
        while (busy && n < 1000) begin
            if (n == 0) chk("R2 midscale while recalling", wiper, 8'h80);
            n++; @(negedge clk);
        end
        m_wiper = m_ivr;
        chk("R2 recall length", n, REC_CYC);
        chk(cold ? "R9 cold recall" : "R9 soft recall", wiper, m_wiper);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        cold_rst_n = 1'b0; rst_n = 1'b0; supply_ok = 1'b0;
        req_wr = 1'b0; req_rd = 1'b0; bus_stop = 1'b0;
        req_addr = 8'h00; req_wdata = 8'h00;
        m_ivr = 8'h80; m_wiper = 8'h80; m_stage = 8'h80;
        m_rd = 8'h00; m_mode = 1'b0; m_pend = 1'b0;

        do_reset(1'b1);
        do_read(8'd2, 1'b1, "R6 mode after reset");
        do_read(8'd0, 1'b1, "R3 read shows stored value");

        // R3 / R5: mirrored write then store.
        do_write(8'd0, 8'h3C, 1'b1);
        chk("R3 wiper direct", wiper, 8'h3C);
        do_read(8'd0, 1'b1, "R3 pending not visible");
        do_stop("R5 store length");
        do_read(8'd0, 1'b1, "R5 stored value");

        // R4 / R6 / R10: volatile-only mode.
        do_write(8'd2, 8'h81, 1'b1);
        do_read(8'd2, 1'b1, "R6 only bit 7 kept");
        do_write(8'd0, 8'hA5, 1'b1);
        chk("R4 wiper only", wiper, 8'hA5);
        do_read(8'd0, 1'b1, "R4 read wiper");
        do_stop("R10 no store without pending");
        do_write(8'd2, 8'h7F, 1'b1);
        do_read(8'd2, 1'b1, "R6 bit 7 clear");
        do_read(8'd0, 1'b1, "R4 back to stored value");

        // R7: reserved addresses.
        do_write(8'd1, 8'hFF, 1'b1);
        do_write(8'h77, 8'h11, 1'b1);
        chk("R7 wiper untouched", wiper, m_wiper);
        do_read(8'd1, 1'b1, "R7 reserved reads zero");
        do_read(8'd2, 1'b1, "R7 mode untouched");
        do_stop("R7 no store");

        // R8 / R11: requests during a store are ignored, rd_data holds.
        do_write(8'd0, 8'h00, 1'b1);
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        chk("R8 busy during store", busy, 1);
        do_write(8'd0, 8'hFF, 1'b0);
        do_write(8'd2, 8'h80, 1'b0);
        do_read(8'd0, 1'b0, "R11 rd_data holds while busy");
        while (busy) @(negedge clk);
        m_ivr = m_stage; m_pend = 1'b0;
        chk("R8 wiper kept", wiper, 8'h00);
        do_read(8'd2, 1'b1, "R8 mode kept");
        do_read(8'd0, 1'b1, "R8 stored value");

        // R9: soft reset keeps the stored value.
        do_write(8'd2, 8'h80, 1'b1);
        do_write(8'd0, 8'h99, 1'b1);
        do_reset(1'b0);
        do_read(8'd2, 1'b1, "R1 mode cleared");

        // Seeded random operations.
        for (int i = 0; i < 200; i++) begin
            int op = $urandom_range(0, 5);
            logic [7:0] d = 8'($urandom);
            logic [7:0] ra;
            case (op)
                0, 1: do_write(8'd0, d, 1'b1);
                2:    do_write(8'd2, d, 1'b1);
                3: begin
                    ra = 8'($urandom);
                    if (ra == 8'd0 || ra == 8'd2) ra = 8'd1;
                    do_write(ra, d, 1'b1);
                end
                4: begin
                    ra = 8'($urandom_range(0, 3));
                    do_read(ra, 1'b1, "R3 R4 R6 R7 random read");
                end
                default: do_stop("R5 R10 random stop");
            endcase
            chk("R3 R4 random wiper", wiper, m_wiper);
        end
        if (m_pend) do_stop("R5 final store");

        do_reset(1'b1);
        chk("R9 cold value", wiper, 8'h80);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule